// File: doc/BRIEF.md
# Dual-Mode SPI Byte Transceiver

This block exchanges one byte at a time over SPI and is reached through a three-register bus interface: a data register, a control register and a status register. It works as a bus master or as a bus slave. As a master it derives SCK from the system clock through a selectable divider. Writing the data register starts the exchange: eight bits go out on MOSI while MISO is captured. The slave-select output is a plain control bit that software drives. As a slave it synchronizes the external SCK, SS and MOSI lines to the system clock. It exchanges a byte only while SS is low, and it releases MISO (output enable low) while SS is high.

The transmit side has a single buffer: the shift register itself. A data write that arrives while a byte is moving is rejected and reported as a collision. The receive side has a double buffer: each completed byte is copied into a receive holding register, which the next completed byte overwrites. A sticky transfer-complete flag, gated by an interrupt enable, drives the interrupt request.

The transfer controller has four states. `ST_IDLE` means no exchange is in progress. In master mode, `ST_M_LOW` is the SCK-low half bit, during which MOSI is presented and MISO is sampled at the end of the half. `ST_M_HIGH` is the SCK-high half bit, at whose end the register shifts. `ST_S_SEL` means the block is selected as a slave. The transitions are:
- start: `ST_IDLE`→`ST_M_LOW` on an accepted data write in master mode.
- half-tick: `ST_M_LOW`→`ST_M_HIGH`.
- next-bit: `ST_M_HIGH`→`ST_M_LOW`.
- finish: `ST_M_HIGH`→`ST_IDLE` after the eighth bit.
- select: `ST_IDLE`→`ST_S_SEL` when the synchronized SS goes low in slave mode.
- deselect: `ST_S_SEL`→`ST_IDLE` on SS high or a switch to master mode.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, the status register (address 2) reads 0x00, the control register (address 1) reads 0x20, `irq`, `sck_out` and `miso_oe` are 0 and `ss_out` is 1.
- R2: In master mode (control bit 0 = 1), a data write (address 0) in idle produces exactly eight SCK pulses in SPI mode 0. MOSI carries the written byte MSB first and is stable while SCK is high.
- R3: In master mode, the byte captured from MISO on the eight rising SCK edges, MSB first, is copied to the receive buffer. After the eighth pulse SCK stays low and status bit 7 (done) becomes 1.
- R4: Each SCK high phase lasts 2^(s+1) system clocks, where s is control bits 4:2. Values above 5 act as 5, giving 64 clocks.
- R5: `irq` is 1 exactly when status bit 7 is 1 and control bit 1 (interrupt enable) is 1.
- R6: `ss_out` always equals control bit 5 and never changes because of a transfer.
- R7: In slave mode (control bit 0 = 0) with SS high, `miso_oe` is 0 and SCK edges shift nothing and set no flag. The data register can still be written.
- R8: In slave mode with SS low, the block drives the data-register byte on MISO MSB first, captures MOSI on rising SCK edges and sets done after the eighth falling edge.
- R9: A data write while a byte is in flight sets status bit 6 (collision) and leaves the byte being shifted unchanged.
- R10: Reading the data register returns the last completed byte. A byte that is not read before the next completion is lost.
- R11: A status read that sees done = 1, followed by a read or write of the data register, clears done and collision. A data access without that prior status read clears neither.
- R12: SCK, SS and MOSI in slave mode pass through two-flop synchronizers. `miso_oe` rises on the third clock edge after SS falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the clear sequence) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Master SCK |
| mosi_out | output | 1 | Master serial data out |
| miso_in | input | 1 | Master serial data in |
| ss_out | output | 1 | Software-driven slave select |
| sck_in | input | 1 | Slave SCK from the external master |
| ss_in | input | 1 | Slave select input, active low |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Output enable for `miso_out` |

## Verification
The hardest case to reach is a data write that lands in the middle of a byte. This matters in slave mode too, where the in-flight window is defined by synchronized SCK edges rather than by the internal divider. The stimulus issues back-to-back master writes on the divider-by-4 setting, so the second write falls inside the first bit. The scoreboard then confirms that MOSI still carried the first byte. A second hard case is a received byte being overwritten before it is read. To reach it, the bench runs two slave exchanges back to back without touching the data register. It reads the buffer only after the second, expecting the second byte.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_M_LOW  = 2'd1,
        ST_M_HIGH = 2'd2,
        ST_S_SEL  = 2'd3
    } xfer_state_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CTRL_MASTER = 0;
    localparam int CTRL_IRQEN  = 1;
    localparam int CTRL_DIV_LO = 2;
    localparam int CTRL_SS     = 5;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int             W   = 3,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage <= {2{RST[g]}};
            else        stage <= {stage[0], d[g]};
        end
        assign q[g] = stage[1];
    end

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int CNT_W = MAX_SEL + 2;

    logic [SEL_W-1:0] eff_sel;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        eff_sel = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
        limit   = (CNT_W'(1) << (eff_sel + 1'b1)) - CNT_W'(1);
        tick    = run && (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == limit) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         master,
    input  logic         load,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    input  logic         miso_in,
    input  logic         sck_s,
    input  logic         ss_s,
    input  logic         mosi_s,
    output xfer_state_e  state,
    output logic [W-1:0] shreg,
    output logic [W-1:0] rx_byte,
    output logic         busy,
    output logic         done,
    output logic         sck_out,
    output logic         mosi_out,
    output logic         miso_out,
    output logic         miso_oe
);

    localparam int          CW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    xfer_state_e   state_d;
    logic [CW-1:0] cnt;
    logic          samp;
    logic          sck_prev;
    logic          s_rise, s_fall;
    logic          m_sample, m_shift, s_sample, s_shift;
    logic          last_bit;

    // edge and event decode
    always_comb begin
        s_rise   = sck_s & ~sck_prev;
        s_fall   = ~sck_s & sck_prev;
        m_sample = (state == ST_M_LOW)  && tick;
        m_shift  = (state == ST_M_HIGH) && tick;
        s_sample = (state == ST_S_SEL)  && s_rise;
        s_shift  = (state == ST_S_SEL)  && s_fall;
        last_bit = (cnt == LAST);
        done     = (m_shift || s_shift) && last_bit;
        busy     = (state == ST_M_LOW) || (state == ST_M_HIGH) ||
                   ((state == ST_S_SEL) && ((cnt != '0) || sck_s || sck_prev));
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (master && load)      state_d = ST_M_LOW;
                else if (!master && !ss_s) state_d = ST_S_SEL;
            end
            ST_M_LOW: begin
                if (tick) state_d = ST_M_HIGH;
            end
            ST_M_HIGH: begin
                if (tick) state_d = last_bit ? ST_IDLE : ST_M_LOW;
            end
            ST_S_SEL: begin
                if (master || ss_s) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            rx_byte  <= '0;
            cnt      <= '0;
            samp     <= 1'b0;
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            if (load) begin
                shreg <= wdata;
                cnt   <= '0;
            end else if (m_sample || s_sample) begin
                samp <= m_sample ? miso_in : mosi_s;
            end else if (m_shift || s_shift) begin
                shreg <= {shreg[W-2:0], samp};
                cnt   <= last_bit ? '0 : cnt + 1'b1;
                if (last_bit) rx_byte <= {shreg[W-2:0], samp};
            end else if ((state == ST_S_SEL) && (state_d == ST_IDLE)) begin
                cnt <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        sck_out  = (state == ST_M_HIGH);
        mosi_out = shreg[W-1];
        miso_out = shreg[W-1];
        miso_oe  = (state == ST_S_SEL);
    end

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sck_out,
    output logic              mosi_out,
    input  logic              miso_in,
    output logic              ss_out,
    input  logic              sck_in,
    input  logic              ss_in,
    input  logic              mosi_in,
    output logic              miso_out,
    output logic              miso_oe
);

    localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1) << CTRL_SS;

    logic [DATA_W-1:0] ctrl_q;
    logic              flag_q, wcol_q, armed_q;
    logic              wr_data, rd_data, rd_stat, data_acc;
    logic              accept, collide, clear_ok;
    logic [2:0]        sync_q;
    logic              div_tick;
    logic              eng_busy, eng_done;
    logic [DATA_W-1:0] eng_shreg, eng_rx;
    xfer_state_e       eng_state;

    always_comb begin
        wr_data  = bus_wr && (bus_addr == ADDR_DATA);
        rd_data  = bus_rd && (bus_addr == ADDR_DATA);
        rd_stat  = bus_rd && (bus_addr == ADDR_STAT);
        data_acc = wr_data || rd_data;
        accept   = wr_data && !eng_busy;
        collide  = wr_data && eng_busy;
        clear_ok = armed_q && data_acc;
    end

    spi_sync #(.W(3), .RST(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, ss_in, mosi_in}),
        .q     (sync_q)
    );

    spi_clkdiv #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((eng_state == ST_M_LOW) || (eng_state == ST_M_HIGH)),
        .sel   (ctrl_q[CTRL_DIV_LO +: SEL_W]),
        .tick  (div_tick)
    );

    spi_engine #(.W(DATA_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .master   (ctrl_q[CTRL_MASTER]),
        .load     (accept),
        .wdata    (bus_wdata),
        .tick     (div_tick),
        .miso_in  (miso_in),
        .sck_s    (sync_q[2]),
        .ss_s     (sync_q[1]),
        .mosi_s   (sync_q[0]),
        .state    (eng_state),
        .shreg    (eng_shreg),
        .rx_byte  (eng_rx),
        .busy     (eng_busy),
        .done     (eng_done),
        .sck_out  (sck_out),
        .mosi_out (mosi_out),
        .miso_out (miso_out),
        .miso_oe  (miso_oe)
    );

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            flag_q  <= 1'b0;
            wcol_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (bus_wr && (bus_addr == ADDR_CTRL)) ctrl_q <= bus_wdata;

            if (eng_done)      flag_q <= 1'b1;
            else if (clear_ok) flag_q <= 1'b0;

            if (collide)       wcol_q <= 1'b1;
            else if (clear_ok) wcol_q <= 1'b0;

            if (rd_stat && flag_q) armed_q <= 1'b1;
            else if (data_acc)     armed_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = eng_rx;
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_STAT: bus_rdata = {flag_q, wcol_q, {(DATA_W-2){1'b0}}};
            default:   bus_rdata = '0;
        endcase
        irq    = flag_q && ctrl_q[CTRL_IRQEN];
        ss_out = ctrl_q[CTRL_SS];
    end

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk
    import spi_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic        ss_out,
    input logic        sck_out,
    input logic        miso_oe,
    input logic        irq,
    input xfer_state_e eng_state,
    input logic [W-1:0] eng_shreg,
    input logic        div_tick,
    input logic        eng_busy,
    input logic        done_w,
    input logic        flag_q,
    input logic        wcol_q,
    input logic        master_q
);

    assert_ss_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == ADDR_CTRL)) |=> $stable(ss_out));

    assert_sck_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_state == ST_IDLE) || (eng_state == ST_S_SEL)) |-> !sck_out);

    assert_byte_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_state == ST_M_LOW) && !div_tick) |=> $stable(eng_shreg));

    assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_DATA) && eng_busy) |=> wcol_q);

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_w |=> flag_q);

    assert_oe_slave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !master_q);

    assert_irq_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

endmodule

bind spi_xcvr spi_xcvr_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ss_out    (ss_out),
    .sck_out   (sck_out),
    .miso_oe   (miso_oe),
    .irq       (irq),
    .eng_state (eng_state),
    .eng_shreg (eng_shreg),
    .div_tick  (div_tick),
    .eng_busy  (eng_busy),
    .done_w    (eng_done),
    .flag_q    (flag_q),
    .wcol_q    (wcol_q),
    .master_q  (ctrl_q[0])
);

// File: tb/spi_xcvr_bench.sv
module spi_xcvr_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, sck_out, mosi_out, ss_out, miso_out, miso_oe;
    logic       miso_in = 1'b0;
    logic       sck_in = 1'b0;
    logic       ss_in = 1'b1;
    logic       mosi_in = 1'b0;

    int  vectors = 0;
    int  miscompares = 0;
    bit  finished = 1'b0;

    logic [7:0] exp_q[$];
    bit         mon_slave = 1'b0;
    logic [7:0] cap_m = 8'h00;
    logic [7:0] cap_s = 8'h00;
    logic [7:0] sm_tx = 8'h00;
    int         sck_pulses = 0;
    int         hi_run = 0;
    int         last_hi = 0;

    always #2 clk = ~clk;

    spi_xcvr u_spi_xcvr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck_out(sck_out), .mosi_out(mosi_out), .miso_in(miso_in),
        .ss_out(ss_out), .sck_in(sck_in), .ss_in(ss_in), .mosi_in(mosi_in),
        .miso_out(miso_out), .miso_oe(miso_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_flag(output logic [7:0] st);
        st = 8'h00;
        for (int i = 0; i < 3000; i++) begin
            bus_read(2'd2, st);
            if (st[7]) break;
        end
    endtask

    // bench-side slave for master mode
    always @(posedge sck_out) begin
        cap_m = {cap_m[6:0], mosi_out};
        sck_pulses++;
    end
    always @(negedge sck_out) begin
        sm_tx   = {sm_tx[6:0], 1'b0};
        miso_in = sm_tx[7];
    end

    // SCK high-phase width measurement
    always @(negedge clk) begin
        if (sck_out) hi_run++;
        else if (hi_run != 0) begin
            last_hi = hi_run;
            hi_run  = 0;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge irq);
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (mon_slave) check("R8 slave MISO byte", cap_s, e);
                else           check("R2 master MOSI byte", cap_m, e);
            end
        end
    end

    // driver: master exchange
    task automatic master_start(input logic [7:0] tx, input logic [7:0] reply, input bit expect_irq);
        sm_tx = reply;
        miso_in = reply[7];
        sck_pulses = 0;
        if (expect_irq) exp_q.push_back(tx);
        bus_write(2'd0, tx);
    endtask

    // driver: slave exchange
    task automatic slave_xfer(input logic [7:0] rx, input logic [7:0] exp_tx, input bit push);
        if (push) exp_q.push_back(exp_tx);
        @(negedge clk);
        ss_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R12 oe after two edges", miso_oe, 1'b0);
        @(negedge clk);
        check("R12 oe after three edges", miso_oe, 1'b1);
        for (int b = 7; b >= 0; b--) begin
            mosi_in = rx[b];
            repeat (6) @(negedge clk);
            sck_in = 1'b1;
            cap_s = {cap_s[6:0], miso_out};
            repeat (6) @(negedge clk);
            sck_in = 1'b0;
        end
        repeat (8) @(negedge clk);
        ss_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] st;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check("R1 irq", irq, 1'b0);
        check("R1 sck_out", sck_out, 1'b0);
        check("R1 miso_oe", miso_oe, 1'b0);
        check("R1 ss_out", ss_out, 1'b1);
        bus_read(2'd2, d); check("R1 status", d, 8'h00);
        bus_read(2'd1, d); check("R1 control", d, 8'h20);

        // master, irq on, ss low, divide by 4
        bus_write(2'd1, 8'h03);
        check("R6 ss_out follows ctrl", ss_out, 1'b0);
        master_start(8'hC3, 8'h5A, 1'b1);
        wait_flag(st);
        check("R3 done flag", st, 8'h80);
        check("R2 eight pulses", sck_pulses, 8);
        check("R4 high phase s=0", last_hi, 2);
        check("R6 ss_out held", ss_out, 1'b0);
        check("R3 sck idle low", sck_out, 1'b0);
        bus_read(2'd0, d); check("R3 rx byte", d, 8'h5A);
        bus_read(2'd2, d); check("R11 cleared", d, 8'h00);

        // divide by 16
        bus_write(2'd1, 8'h0B);
        master_start(8'h96, 8'h0F, 1'b1);
        wait_flag(st);
        check("R4 high phase s=2", last_hi, 8);
        bus_read(2'd0, d); check("R3 rx byte 2", d, 8'h0F);

        // select 7 clamps to 5
        bus_write(2'd1, 8'h1F);
        master_start(8'h01, 8'h80, 1'b1);
        wait_flag(st);
        check("R4 high phase clamp", last_hi, 64);
        check("R2 eight pulses slow", sck_pulses, 8);
        bus_read(2'd0, d); check("R3 rx byte 3", d, 8'h80);

        // collision mid-byte
        bus_write(2'd1, 8'h03);
        master_start(8'hE7, 8'h24, 1'b1);
        bus_write(2'd0, 8'h18);
        wait_flag(st);
        check("R9 collision bit", st, 8'hC0);
        bus_read(2'd0, d); check("R9 rx intact", d, 8'h24);
        bus_read(2'd2, d); check("R11 collision cleared", d, 8'h00);

        // data read without status read does not clear
        master_start(8'h6D, 8'hB2, 1'b1);
        repeat (60) @(negedge clk);
        bus_read(2'd0, d); check("R10 rx before clear", d, 8'hB2);
        bus_read(2'd2, d); check("R11 flag survives bare data read", d, 8'h80);
        bus_read(2'd0, d);
        bus_read(2'd2, d); check("R11 flag cleared by sequence", d, 8'h00);

        // irq gated by enable
        bus_write(2'd1, 8'h01);
        master_start(8'h33, 8'h44, 1'b0);
        repeat (60) @(negedge clk);
        check("R5 irq masked", irq, 1'b0);
        bus_read(2'd2, d); check("R5 flag set while masked", d, 8'h80);
        bus_write(2'd1, 8'h03);
        @(negedge clk);
        check("R5 irq after enable", irq, 1'b1);
        bus_read(2'd0, d);
        @(negedge clk);
        check("R5 irq drops after clear", irq, 1'b0);

        // slave mode, ss high: ignored
        mon_slave = 1'b1;
        bus_write(2'd1, 8'h22);
        check("R6 ss_out high", ss_out, 1'b1);
        bus_write(2'd0, 8'hA5);
        for (int p = 0; p < 8; p++) begin
            mosi_in = p[0];
            repeat (6) @(negedge clk);
            sck_in = 1'b1;
            check("R7 oe off while deselected", miso_oe, 1'b0);
            repeat (6) @(negedge clk);
            sck_in = 1'b0;
        end
        repeat (6) @(negedge clk);
        bus_read(2'd2, d); check("R7 no flag while deselected", d, 8'h00);

        // slave exchange
        slave_xfer(8'h3C, 8'hA5, 1'b1);
        check("R7 oe off after deselect", miso_oe, 1'b0);
        wait_flag(st);
        check("R8 slave done", st, 8'h80);
        bus_read(2'd0, d); check("R8 slave rx", d, 8'h3C);

        // overrun: second byte replaces first
        bus_write(2'd0, 8'h11);
        slave_xfer(8'h81, 8'h11, 1'b1);
        bus_write(2'd0, 8'h22);
        slave_xfer(8'h42, 8'h22, 1'b0);
        check("R8 second slave MISO byte", cap_s, 8'h22);
        bus_read(2'd2, d);
        bus_read(2'd0, d); check("R10 first byte lost", d, 8'h42);
        bus_read(2'd2, d); check("R11 slave flag cleared", d, 8'h00);

        repeat (20) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);
        report();
    end

endmodule